// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical raster timing for a display pipe. It runs a pixel counter along each line and a line counter down each frame. From them it derives horizontal sync, vertical sync, a blanking flag, a display-enable flag and the x/y coordinates of the pixel being shown. The geometry of a mode is not fixed. Software loads it through a small address/data register port: one register each for the active, blank and sync windows of each axis, a control register that holds a run bit, and a key register that guards all the others.

Each timing register carries two 16-bit positions stored as count minus one. The lower field is the first position and the upper field is the second. Software unlocks the file with the key, clears the run bit, loads the six timing registers and sets the run bit again. Timing writes made while the generator runs are held in a pending copy. That copy replaces the live timing only at a frame boundary, so no frame mixes old and new geometry.

Top module: `scan_timing_gen`

## Requirements
- R1: After reset the file is locked, the run bit is 0, every register reads 0, blank is 1, hsync, vsync and display-enable are 0, and x and y are 0.
- R2: A write of 0x00004758 to address 0 unlocks the file, and a write of any other value to address 0 locks it. Reading address 0 returns 1 when unlocked and 0 when locked.
- R3: While the file is locked, writes to addresses 1 to 7 are ignored. Address 1 bit 0 is the run bit, and its readback and the outputs stay unchanged.
- R4: The timing registers sit at address 2 (horizontal active), 3 (horizontal blank), 4 (horizontal sync), 5 (vertical active), 6 (vertical blank) and 7 (vertical sync). A read returns the last 32-bit value accepted: bits 15:0 hold the first field and bits 31:16 the second. For the active registers these are active count minus one and total count minus one.
- R5: While the run bit is 0, both counters stay at 0, blank is 1, both syncs are 0, display-enable is 0, and x and y are 0.
- R6: While running, the pixel count steps 0, 1, ... up to the horizontal total field and then wraps to 0. The line count advances only on that wrap, and it wraps to 0 after its own total field.
- R7: Hsync is 1 when the pixel count is greater than the horizontal sync first field and no greater than its second field. Vsync follows the same rule on the line count with the vertical sync register.
- R8: Blank is 1 when the pixel count lies above the horizontal blank first field and at or below its second field, or when the line count lies in the same window of the vertical blank register.
- R9: Display-enable is 1 when the pixel count is at or below the horizontal active first field and the line count is at or below the vertical active first field. At those times x and y equal the counts; at all other times they are 0.
- R10: Timing writes accepted while running reach the live timing only in the cycle in which both counters wrap together, and the new frame starts with them. While stopped, they take effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address for both writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Blanking interval flag |
| de | output | 1 | Display-enable |
| pix_x | output | 16 | Pixel column while display-enable is 1, otherwise 0 |
| pix_y | output | 16 | Line number while display-enable is 1, otherwise 0 |

## Verification
The bench targets the boundaries of each window. If a comparator were off by one, sync, blank or display-enable would move by a pixel at the last active pixel or at the first or last sync pixel, and the model would flag that edge. It reprograms a wider line partway through a running frame. A design that applied the write at once, or only at a line wrap, would change the horizontal period before the frame ends. It also writes the timing, control and key registers while the file is locked, so a leaky lock shows up as a changed readback or as counters that start running.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned DATA_W  = 2 * FIELD_W;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned N_TREG  = 6;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_4758;

  localparam logic [ADDR_W-1:0] A_KEY  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_TIM0 = 3'd2;

  typedef struct packed {
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;
  } span_t;

  typedef struct packed {
    span_t act;
    span_t blk;
    span_t syn;
  } axis_cfg_t;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
  import scan_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_end,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output axis_cfg_t         live_h,
  output axis_cfg_t         live_v
);
  logic unlocked_q, unlocked_d;
  logic run_d;
  span_t [N_TREG-1:0] pend_q;
  axis_cfg_t live_h_d, live_v_d;
  logic load;

  always_comb begin
    unlocked_d = unlocked_q;
    if (wr_en && addr == A_KEY) unlocked_d = (wdata == UNLOCK_KEY);
    run_d = run;
    if (wr_en && unlocked_q && addr == A_CTRL) run_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      run        <= 1'b0;
    end else begin
      unlocked_q <= unlocked_d;
      run        <= run_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_TREG; gi++) begin : g_pend
      localparam logic [ADDR_W-1:0] SLOT = A_TIM0 + ADDR_W'(gi);
      span_t pend_d;
      always_comb begin
        pend_d = pend_q[gi];
        if (wr_en && unlocked_q && addr == SLOT) pend_d = span_t'(wdata);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q[gi] <= '0;
        else        pend_q[gi] <= pend_d;
      end
    end
  endgenerate

  // Live copy follows pending while stopped, otherwise only at frame end.
  always_comb begin
    load     = !run || frame_end;
    live_h_d = live_h;
    live_v_d = live_v;
    if (load) begin
      live_h_d = '{act: pend_q[0], blk: pend_q[1], syn: pend_q[2]};
      live_v_d = '{act: pend_q[3], blk: pend_q[4], syn: pend_q[5]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_h <= '0;
      live_v <= '0;
    end else begin
      live_h <= live_h_d;
      live_v <= live_v_d;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = {{(DATA_W-1){1'b0}}, unlocked_q};
      3'd1:    rdata = {{(DATA_W-1){1'b0}}, run};
      3'd2:    rdata = pend_q[0];
      3'd3:    rdata = pend_q[1];
      3'd4:    rdata = pend_q[2];
      3'd5:    rdata = pend_q[3];
      3'd6:    rdata = pend_q[4];
      default: rdata = pend_q[5];
    endcase
  end

  p_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_KEY) |=> (unlocked_q == ($past(wdata) == UNLOCK_KEY)));

  p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_KEY && !unlocked_q) |=> ($stable(pend_q) && $stable(run)));

  p_shadow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> ($stable(live_h) && $stable(live_v)));
endmodule

// File: rtl/scan_axis.sv
module scan_axis
  import scan_timing_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               step,
  input  axis_cfg_t          cfg,
  output logic [FIELD_W-1:0] count,
  output logic               wrap,
  output logic               in_active,
  output logic               in_blank,
  output logic               in_sync
);
  logic [FIELD_W-1:0] count_d;

  always_comb begin
    wrap = run && step && (count == cfg.act.hi);
    if (!run)      count_d = '0;
    else if (wrap) count_d = '0;
    else if (step) count_d = count + FIELD_W'(1);
    else           count_d = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  always_comb begin
    in_active = (count <= cfg.act.lo);
    in_blank  = (count > cfg.blk.lo) && (count <= cfg.blk.hi);
    in_sync   = (count > cfg.syn.lo) && (count <= cfg.syn.hi);
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && count == cfg.act.hi) |=> (count == '0));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && count != cfg.act.hi) |=> (count == $past(count) + FIELD_W'(1)));
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              blank,
  output logic              de,
  output logic [FIELD_W-1:0] pix_x,
  output logic [FIELD_W-1:0] pix_y
);
  localparam int unsigned N_AXIS = 2;

  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic      run;
  axis_cfg_t live_h, live_v;
  axis_cfg_t cfg_a [N_AXIS];
  logic [FIELD_W-1:0] cnt_a [N_AXIS];
  logic [N_AXIS-1:0] step_a, wrap_a, act_a, blk_a, syn_a;

  scan_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .frame_end (wrap_a[1]),
    .rdata     (rdata),
    .run       (run),
    .live_h    (live_h),
    .live_v    (live_v)
  );

  assign cfg_a[0]  = live_h;
  assign cfg_a[1]  = live_v;
  assign step_a[0] = 1'b1;
  assign step_a[1] = wrap_a[0];

  genvar ga;
  generate
    for (ga = 0; ga < N_AXIS; ga++) begin : g_axis
      scan_axis u_axis (
        .clk       (clk),
        .rst_n     (rst_i_n),
        .run       (run),
        .step      (step_a[ga]),
        .cfg       (cfg_a[ga]),
        .count     (cnt_a[ga]),
        .wrap      (wrap_a[ga]),
        .in_active (act_a[ga]),
        .in_blank  (blk_a[ga]),
        .in_sync   (syn_a[ga])
      );
    end
  endgenerate

  always_comb begin
    hsync = run && syn_a[0];
    vsync = run && syn_a[1];
    blank = !run || blk_a[0] || blk_a[1];
    de    = run && act_a[0] && act_a[1];
    pix_x = de ? cnt_a[0] : '0;
    pix_y = de ? cnt_a[1] : '0;
  end

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !run |-> (blank && !hsync && !vsync && !de));
endmodule

// File: tb/scan_timing_gen_test.sv
module scan_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        hsync, vsync, blank, de;
  logic [15:0] pix_x, pix_y;

  int n_checks = 0;
  int n_fail   = 0;
  string phase = "";
  bit done = 0;

  always #4 clk = ~clk;

  scan_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hsync(hsync), .vsync(vsync), .blank(blank), .de(de),
    .pix_x(pix_x), .pix_y(pix_y)
  );

  // Behavioural reference state
  int rel = 0;
  int m_unl = 0, m_en = 0, m_h = 0, m_v = 0;
  logic [31:0] m_pend [6];
  logic [31:0] m_live [6];

  initial begin
    for (int i = 0; i < 6; i++) begin m_pend[i] = 0; m_live[i] = 0; end
  end

  function automatic int f_lo(logic [31:0] v); return int'(v[15:0]); endfunction
  function automatic int f_hi(logic [31:0] v); return int'(v[31:16]); endfunction
  function automatic bit in_win(int c, logic [31:0] v);
    return (c > f_lo(v)) && (c <= f_hi(v));
  endfunction

  always @(posedge clk) begin
    if (!rst_n || rel < 2) begin
      if (rst_n) rel++; else rel = 0;
      m_unl = 0; m_en = 0; m_h = 0; m_v = 0;
      for (int i = 0; i < 6; i++) begin m_pend[i] = 0; m_live[i] = 0; end
    end else begin
      int o_en, o_unl, oh, ov, ht, vt;
      bit fe;
      logic [31:0] o_pend [6];
      o_en = m_en; o_unl = m_unl; oh = m_h; ov = m_v;
      for (int i = 0; i < 6; i++) o_pend[i] = m_pend[i];
      ht = f_hi(m_live[0]); vt = f_hi(m_live[3]);
      fe = (o_en != 0) && oh == ht && ov == vt;
      if (wr_en) begin
        if (addr == 0) m_unl = (wdata == 32'h0000_4758);
        else if (o_unl != 0) begin
          if (addr == 1) m_en = int'(wdata[0]);
          else m_pend[int'(addr) - 2] = wdata;
        end
      end
      if (o_en == 0 || fe) for (int i = 0; i < 6; i++) m_live[i] = o_pend[i];
      if (o_en == 0) begin m_h = 0; m_v = 0; end
      else if (oh == ht) begin m_h = 0; m_v = (ov == vt) ? 0 : ov + 1; end
      else m_h = oh + 1;
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tg(string dflt);
    return (phase != "") ? phase : dflt;
  endfunction

  always @(posedge clk) begin
    #2;
    if (!done) begin
      bit e_hs, e_vs, e_bl, e_de;
      logic [31:0] e_rd;
      e_hs = (m_en != 0) && in_win(m_h, m_live[2]);
      e_vs = (m_en != 0) && in_win(m_v, m_live[5]);
      e_bl = (m_en == 0) || in_win(m_h, m_live[1]) || in_win(m_v, m_live[4]);
      e_de = (m_en != 0) && m_h <= f_lo(m_live[0]) && m_v <= f_lo(m_live[3]);
      case (addr)
        3'd0: e_rd = 32'(m_unl);
        3'd1: e_rd = 32'(m_en);
        default: e_rd = m_pend[int'(addr) - 2];
      endcase
      chk(tg("R7"), "hsync", hsync, e_hs);
      chk(tg("R7"), "vsync", vsync, e_vs);
      chk(tg("R8"), "blank", blank, e_bl);
      chk(tg("R9"), "de", de, e_de);
      chk(tg("R6"), "pix_x", pix_x, e_de ? m_h : 0);
      chk(tg("R6"), "pix_y", pix_y, e_de ? m_v : 0);
      chk(tg(addr == 0 ? "R2" : (addr == 1 ? "R3" : "R4")), "rdata", rdata, e_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic sel(input logic [2:0] a);
    @(negedge clk); addr = a;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    phase = "R1";
    for (int a = 0; a < 8; a++) sel(3'(a));
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    phase = "R3";
    wr(3'd2, 32'h0000_0005);
    sel(3'd2);
    wr(3'd1, 32'h1);
    sel(3'd1); idle(3);
    wr(3'd0, 32'h0000_4759);
    sel(3'd0);
    phase = "";
    wr(3'd0, 32'h0000_4758);
    sel(3'd0);
    // mode: 6 active pixels, total 13; 4 active lines, total 8
    wr(3'd2, {16'd12, 16'd5});
    wr(3'd3, {16'd12, 16'd5});
    wr(3'd4, {16'd10, 16'd7});
    wr(3'd5, {16'd7, 16'd3});
    wr(3'd6, {16'd7, 16'd3});
    wr(3'd7, {16'd6, 16'd4});
    for (int a = 2; a < 8; a++) sel(3'(a));
    phase = "R5";
    idle(3);
    phase = "";
    wr(3'd1, 32'h1);
    idle(20);
    phase = "R10";
    // wider line while running: 8 active, total 16
    wr(3'd2, {16'd15, 16'd7});
    wr(3'd3, {16'd15, 16'd7});
    wr(3'd4, {16'd12, 16'd9});
    sel(3'd2);
    idle(240);
    phase = "";
    idle(130);
    wr(3'd0, 32'h0);
    sel(3'd0);
    phase = "R3";
    wr(3'd1, 32'h0);
    wr(3'd7, 32'hABCD_1234);
    sel(3'd7);
    idle(20);
    phase = "";
    wr(3'd0, 32'h0000_4758);
    wr(3'd1, 32'h0);
    sel(3'd1);
    phase = "R5";
    idle(10);
    phase = "";
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    done = 1;
    n_checks++; n_fail++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule